// File: doc/BRIEF.md
# Programmable Filter Step Sequencer

This block is the control store and microsequencer for the filter compute engine of one channel in a multi-channel downconverter. It holds up to 32 program steps, each a 128-bit word. Executing a step either launches one filter pass or performs a flow operation: a wait on a condition input, a jump, a loop-counter load, or a no-operation. A filter launch sends a one-cycle start strobe together with the step's parameter field and a starting read address. The sequencer then stalls until the engine reports completion.

A host loads the program through a 32-bit bus, one quarter of a word per access. The host reaches the store only while the external hold control is asserted. The same hold also freezes program execution, so a program is loaded with hold set and then started by releasing it. The block keeps a data write pointer that advances on every incoming sample. A filter's start read address is that pointer plus a per-step offset, so the members of a polyphase bank can read shifted positions of the same stored data.

Top module: `flt_step_seq`

## Requirements
- R1: Reset sets `curStep` to 31, clears `filtStart`, `filtParam`, `filtRdAddr`, `filtWrAddr`, `hostRData` and the loop counter, and parks the sequencer. The first cycle with `holdBit` low then moves to step 0 without executing anything, and execution starts from step 0.
- R2: Host address layout:
  - `hostAddr[15:12]` must equal the parameter CHAN_ID (default 5).
  - `hostAddr[11:7]` must equal 5'b00010.
  - `hostAddr[6:2]` selects the step.
  - `hostAddr[1:0]` selects the quarter: 0 is bits 31:0, 1 is bits 63:32, 2 is bits 95:64 and 3 is bits 127:96.

  A write stores `hostWData` in that quarter. A read loads that quarter into `hostRData` one cycle later.
- R3: A host access is ignored when `holdBit` is low or when the address does not match. The store is unchanged and `hostRData` keeps its value.
- R4: When `holdBit` is high, no `filtStart` is produced and `curStep` does not move. The one exception is a pending filter, which still completes on `filtDone`.
- R5: Instruction word layout:
  - Bits 2:0 are the kind: 0 NOP, 1 filter, 2 wait, 3 jump, 4 load counter, with other values acting as NOP.
  - Bits 4:3 are the jump mode.
  - Bits 6:5 select the condition.
  - Bits 20:16 are the jump target.
  - Bits 47:32 are the counter preload.
  - Bits 54:48 are the read offset.
  - Bits 127:64 are the filter parameters.

  A NOP step advances `curStep` by one.
- R6: A filter step raises `filtStart` for exactly one cycle. In that same cycle `filtParam` shows bits 127:64 and `filtRdAddr` shows the write pointer plus the offset, modulo 128. The step advances on the first `filtDone` after the launch.
- R7: A wait step advances only in a cycle where `condIn[sel]` is high. Otherwise it stays on the same step.
- R8: A jump step branches to its target as follows:
  - Mode 0 always branches.
  - Mode 1 branches when `condIn[sel]` is high.
  - Mode 3 acts as mode 0.
  - When a jump does not branch, the sequencer goes to the next step.
- R9: A load-counter step copies bits 47:32 into the loop counter. A mode 2 jump branches and decrements the counter while the counter is nonzero, and falls through when it is zero.
- R10: Step advance wraps from 31 to 0.
- R11: `filtWrAddr` increments by one, modulo 128, in every cycle that `sampleIn` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hostAddr | input | 16 | Host word address |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostWData | input | 32 | Host write data |
| hostRData | output | 32 | Host read data, registered |
| holdBit | input | 1 | Host hold: opens the store, freezes execution |
| condIn | input | 4 | Condition flags for wait and jump steps |
| filtDone | input | 1 | Filter pass complete |
| sampleIn | input | 1 | New sample written to the data store |
| filtStart | output | 1 | One-cycle filter launch strobe |
| filtParam | output | 64 | Parameters of the launched filter |
| filtRdAddr | output | 7 | Starting read address of the launched filter |
| filtWrAddr | output | 7 | Data write pointer |
| curStep | output | 5 | Current instruction pointer |

## Verification
The hardest state to reach is a conditional loop whose counter reaches zero while filter steps inside the loop are waiting on a random done input. That state needs a host-loaded program, a release of hold, and many loop passes. Condition inputs are random, so exit from a wait and conditional branching are left to chance. The bench therefore runs a looping program for thousands of cycles under pseudo-random `filtDone`, `condIn` and `sampleIn`. It releases and reasserts hold in windows, and it mixes host reads and writes into both the hold-high and the hold-low phases. A behavioural model tracks every output on every cycle.

// File: rtl/flt_seq_pkg.sv
package flt_seq_pkg;
  localparam int STEP_W  = 5;
  localparam int DEPTH   = 1 << STEP_W;
  localparam int WORD_W  = 128;
  localparam int HOST_W  = 32;
  localparam int QTR_W   = 2;
  localparam int LOOP_W  = 16;
  localparam int DADDR_W = 7;
  localparam int PARAM_W = 64;
  localparam int NCOND   = 4;
  localparam int CSEL_W  = 2;

  // field positions
  localparam int KIND_LSB = 0;
  localparam int MODE_LSB = 3;
  localparam int CSEL_LSB = 5;
  localparam int TGT_LSB  = 16;
  localparam int PRE_LSB  = 32;
  localparam int OFS_LSB  = 48;
  localparam int PAR_LSB  = 64;

  typedef enum logic [2:0] {
    K_NOP = 3'd0, K_FILT = 3'd1, K_WAIT = 3'd2, K_JUMP = 3'd3, K_LOAD = 3'd4
  } kind_e;

  typedef enum logic [1:0] {
    S_PARK = 2'd0, S_RUN = 2'd1, S_BUSY = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic adv;
    logic jmp;
    logic cntLd;
    logic cntDec;
    logic launch;
  } seq_strb_t;
endpackage

// File: rtl/seq_imem.sv
module seq_imem
  import flt_seq_pkg::*;
#(
  parameter logic [3:0] CHAN_ID = 4'd5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [15:0]          hostAddr,
  input  logic                 hostWr,
  input  logic                 hostRd,
  input  logic [HOST_W-1:0]    hostWData,
  input  logic                 holdBit,
  output logic [HOST_W-1:0]    hostRData,
  input  logic [STEP_W-1:0]    exeAddr,
  output logic [WORD_W-1:0]    exeWord
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic              addrHit;
  logic [STEP_W-1:0] hStep;
  logic [QTR_W-1:0]  hQtr;

  assign addrHit = (hostAddr[15:12] == CHAN_ID) && (hostAddr[11:7] == 5'b00010);
  assign hStep   = hostAddr[2 +: STEP_W];
  assign hQtr    = hostAddr[QTR_W-1:0];
  assign exeWord = mem[exeAddr];

  always_ff @(posedge clk) begin
    if (holdBit && addrHit && hostWr)
      mem[hStep][int'(hQtr)*HOST_W +: HOST_W] <= hostWData;
  end

  always_ff @(posedge clk) begin
    if (rst)
      hostRData <= '0;
    else if (holdBit && addrHit && hostRd)
      hostRData <= mem[hStep][int'(hQtr)*HOST_W +: HOST_W];
  end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import flt_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              holdBit,
  input  logic [2:0]        kind,
  input  logic [1:0]        jmode,
  input  logic [CSEL_W-1:0] csel,
  input  logic [NCOND-1:0]  condIn,
  input  logic              filtDone,
  input  logic              cntZero,
  output seq_strb_t         strb
);
  seq_state_e state, stateNxt;
  logic       condHit;

  assign condHit = condIn[csel];

  always_comb begin
    strb     = '0;
    stateNxt = state;
    unique case (state)
      S_PARK: if (!holdBit) begin
        strb.adv = 1'b1;
        stateNxt = S_RUN;
      end
      S_BUSY: if (filtDone) begin
        strb.adv = 1'b1;
        stateNxt = S_RUN;
      end
      default: if (!holdBit) begin
        case (kind)
          K_FILT: begin
            strb.launch = 1'b1;
            stateNxt    = S_BUSY;
          end
          K_WAIT: strb.adv = condHit;
          K_JUMP: begin
            case (jmode)
              2'd1:    begin strb.jmp = condHit; strb.adv = !condHit; end
              2'd2:    begin strb.jmp = !cntZero; strb.cntDec = !cntZero; strb.adv = cntZero; end
              default: strb.jmp = 1'b1;
            endcase
          end
          K_LOAD: begin
            strb.cntLd = 1'b1;
            strb.adv   = 1'b1;
          end
          default: strb.adv = 1'b1;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_PARK;
    else     state <= stateNxt;
  end
endmodule

// File: rtl/seq_dpath.sv
module seq_dpath
  import flt_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  seq_strb_t          strb,
  input  logic [WORD_W-1:0]  word,
  input  logic               sampleIn,
  output logic [STEP_W-1:0]  curStep,
  output logic               cntZero,
  output logic               filtStart,
  output logic [PARAM_W-1:0] filtParam,
  output logic [DADDR_W-1:0] filtRdAddr,
  output logic [DADDR_W-1:0] filtWrAddr
);
  logic [LOOP_W-1:0] loopCnt;

  assign cntZero = (loopCnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      curStep    <= STEP_W'(DEPTH - 1);
      loopCnt    <= '0;
      filtStart  <= 1'b0;
      filtParam  <= '0;
      filtRdAddr <= '0;
      filtWrAddr <= '0;
    end else begin
      filtStart <= strb.launch;
      if (sampleIn) filtWrAddr <= filtWrAddr + 1'b1;
      if (strb.jmp)      curStep <= word[TGT_LSB +: STEP_W];
      else if (strb.adv) curStep <= curStep + 1'b1;
      if (strb.cntLd)       loopCnt <= word[PRE_LSB +: LOOP_W];
      else if (strb.cntDec) loopCnt <= loopCnt - 1'b1;
      if (strb.launch) begin
        filtParam  <= word[PAR_LSB +: PARAM_W];
        filtRdAddr <= filtWrAddr + word[OFS_LSB +: DADDR_W];
      end
    end
  end
endmodule

// File: rtl/flt_step_seq.sv
module flt_step_seq
  import flt_seq_pkg::*;
#(
  parameter logic [3:0] CHAN_ID = 4'd5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [15:0]          hostAddr,
  input  logic                 hostWr,
  input  logic                 hostRd,
  input  logic [HOST_W-1:0]    hostWData,
  output logic [HOST_W-1:0]    hostRData,
  input  logic                 holdBit,
  input  logic [NCOND-1:0]     condIn,
  input  logic                 filtDone,
  input  logic                 sampleIn,
  output logic                 filtStart,
  output logic [PARAM_W-1:0]   filtParam,
  output logic [DADDR_W-1:0]   filtRdAddr,
  output logic [DADDR_W-1:0]   filtWrAddr,
  output logic [STEP_W-1:0]    curStep
);
  logic [WORD_W-1:0] exeWord;
  seq_strb_t         strb;
  logic              cntZero;

  seq_imem #(.CHAN_ID(CHAN_ID)) u_imem (
    .clk(clk), .rst(rst), .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .hostWData(hostWData), .holdBit(holdBit), .hostRData(hostRData),
    .exeAddr(curStep), .exeWord(exeWord)
  );

  seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .holdBit(holdBit),
    .kind(exeWord[KIND_LSB +: 3]), .jmode(exeWord[MODE_LSB +: 2]),
    .csel(exeWord[CSEL_LSB +: CSEL_W]), .condIn(condIn),
    .filtDone(filtDone), .cntZero(cntZero), .strb(strb)
  );

  seq_dpath u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .word(exeWord), .sampleIn(sampleIn),
    .curStep(curStep), .cntZero(cntZero), .filtStart(filtStart),
    .filtParam(filtParam), .filtRdAddr(filtRdAddr), .filtWrAddr(filtWrAddr)
  );
endmodule

// File: rtl/flt_step_seq_chk.sv
module flt_step_seq_chk
  import flt_seq_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               holdBit,
  input logic               filtDone,
  input logic               sampleIn,
  input logic               filtStart,
  input logic [DADDR_W-1:0] filtWrAddr,
  input logic [STEP_W-1:0]  curStep
);
  p_reset_park_r1: assert property (@(posedge clk)
    rst |=> (curStep == STEP_W'(DEPTH - 1)) && !filtStart);

  p_hold_no_start_r4: assert property (@(posedge clk) disable iff (rst)
    filtStart |-> !$past(holdBit));

  p_hold_stall_r4: assert property (@(posedge clk) disable iff (rst)
    (holdBit && !filtDone) |=> $stable(curStep));

  p_start_single_r6: assert property (@(posedge clk) disable iff (rst)
    filtStart |=> !filtStart);

  p_start_no_move_r6: assert property (@(posedge clk) disable iff (rst)
    filtStart |-> $stable(curStep));

  p_wr_step_r11: assert property (@(posedge clk) disable iff (rst)
    sampleIn |=> filtWrAddr == DADDR_W'($past(filtWrAddr) + 1'b1));
endmodule

bind flt_step_seq flt_step_seq_chk u_chk (
  .clk(clk), .rst(rst), .holdBit(holdBit), .filtDone(filtDone), .sampleIn(sampleIn),
  .filtStart(filtStart), .filtWrAddr(filtWrAddr), .curStep(curStep)
);

// File: tb/flt_step_seq_bench.sv
module flt_step_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [15:0]  hostAddr = '0;
  logic         hostWr = 1'b0, hostRd = 1'b0;
  logic [31:0]  hostWData = '0;
  logic [31:0]  hostRData;
  logic         holdBit = 1'b1;
  logic [3:0]   condIn = '0;
  logic         filtDone = 1'b0, sampleIn = 1'b0;
  logic         filtStart;
  logic [63:0]  filtParam;
  logic [6:0]   filtRdAddr, filtWrAddr;
  logic [4:0]   curStep;

  int compared = 0, mismatched = 0;
  bit running = 1'b0;

  flt_step_seq u_flt_step_seq (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  logic [127:0] mMem [32];
  int  mPtr, mState, mCnt, mWr, mRd;  // mState: 0 park 1 run 2 busy
  logic        mStart;
  logic [63:0] mParam;
  logic [31:0] mRData;

  always @(posedge clk) begin
    if (rst) begin
      mPtr = 31; mState = 0; mCnt = 0; mWr = 0; mRd = 0;
      mStart = 0; mParam = '0; mRData = '0;
    end else begin
      logic [127:0] w;
      bit hit;
      int q, s;
      w = mMem[mPtr];
      hit = holdBit && hostAddr[15:12] == 4'd5 && hostAddr[11:7] == 5'b00010;
      s = int'(hostAddr[6:2]); q = int'(hostAddr[1:0]);
      if (hit && hostRd) mRData = mMem[s][q*32 +: 32];
      if (hit && hostWr) mMem[s][q*32 +: 32] = hostWData;
      mStart = 0;
      if (mState == 0) begin
        if (!holdBit) begin mPtr = (mPtr + 1) % 32; mState = 1; end
      end else if (mState == 2) begin
        if (filtDone) begin mPtr = (mPtr + 1) % 32; mState = 1; end
      end else if (!holdBit) begin
        int kind, mode;
        bit c;
        kind = int'(w[2:0]); mode = int'(w[4:3]); c = condIn[w[6:5]];
        if (kind == 1) begin
          mStart = 1; mParam = w[127:64]; mRd = (mWr + int'(w[54:48])) % 128; mState = 2;
        end else if (kind == 2) begin
          if (c) mPtr = (mPtr + 1) % 32;
        end else if (kind == 3) begin
          if (mode == 1) mPtr = c ? int'(w[20:16]) : (mPtr + 1) % 32;
          else if (mode == 2) begin
            if (mCnt != 0) begin mCnt--; mPtr = int'(w[20:16]); end
            else mPtr = (mPtr + 1) % 32;
          end else mPtr = int'(w[20:16]);
        end else if (kind == 4) begin
          mCnt = int'(w[47:32]); mPtr = (mPtr + 1) % 32;
        end else mPtr = (mPtr + 1) % 32;
      end
      if (sampleIn) mWr = (mWr + 1) % 128;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (running && !rst) begin
    chk("R1/R5/R7/R8/R9/R10 curStep", 64'(curStep), 64'(mPtr));
    chk("R4/R6 filtStart", 64'(filtStart), 64'(mStart));
    chk("R6 filtParam", filtParam, mParam);
    chk("R6 filtRdAddr", 64'(filtRdAddr), 64'(mRd));
    chk("R11 filtWrAddr", 64'(filtWrAddr), 64'(mWr));
    chk("R2/R3 hostRData", 64'(hostRData), 64'(mRData));
  end

  function automatic logic [127:0] mk(input int kind, input int mode, input int sel,
      input int tgt, input int pre, input int ofs, input logic [63:0] par);
    logic [127:0] w = '0;
    w[2:0] = 3'(kind); w[4:3] = 2'(mode); w[6:5] = 2'(sel);
    w[20:16] = 5'(tgt); w[47:32] = 16'(pre); w[54:48] = 7'(ofs); w[127:64] = par;
    return w;
  endfunction

  task automatic hostWrite(input logic [3:0] ch, input int step, input logic [127:0] w);
    for (int q = 0; q < 4; q++) begin
      @(negedge clk);
      hostAddr = {ch, 5'b00010, 5'(step), 2'(q)};
      hostWData = w[q*32 +: 32]; hostWr = 1'b1;
    end
    @(negedge clk); hostWr = 1'b0;
  endtask

  task automatic hostRead(input int step, input int q);
    @(negedge clk);
    hostAddr = {4'd5, 5'b00010, 5'(step), 2'(q)}; hostRd = 1'b1;
    @(negedge clk); hostRd = 1'b0;
  endtask

  logic [15:0] lfsr = 16'hACE1;
  bit randOn = 1'b0;
  always @(negedge clk) if (randOn) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    filtDone = lfsr[0] & lfsr[3];
    condIn   = lfsr[7:4];
    sampleIn = lfsr[9];
  end

  initial begin
    logic [127:0] prog [32];
    for (int i = 0; i < 32; i++) begin
      prog[i] = mk(0, 0, 0, 0, 0, 0, 64'(i));
      mMem[i] = '0;
    end
    prog[0] = mk(4, 0, 0, 0, 2, 0, '0);                      // R9 load 2
    prog[1] = mk(1, 0, 0, 0, 0, 3, 64'h1111_2222_3333_4444);  // R6 offset 3
    prog[2] = mk(3, 2, 0, 1, 0, 0, '0);                      // R9 loop to 1
    prog[3] = mk(2, 0, 1, 0, 0, 0, '0);                      // R7 wait cond1
    prog[4] = mk(3, 1, 0, 6, 0, 0, '0);                      // R8 cond jump
    prog[5] = mk(1, 0, 0, 0, 0, 127, 64'hdead_beef_0000_0005);// R6 wrap add
    prog[6] = mk(1, 0, 0, 0, 0, 0, 64'h0bad_f00d_0000_0006);
    prog[7] = mk(3, 0, 0, 29, 0, 0, '0);                     // R8 uncond
    prog[29] = mk(3, 3, 0, 30, 0, 0, '0);                    // R8 mode 3
    prog[31] = mk(7, 0, 0, 0, 0, 0, '0);                     // R5 other kind, R10 wrap
    repeat (3) @(negedge clk);
    rst = 1'b0;
    running = 1'b1;
    @(negedge clk);
    // R1: reset values, parked while hold high
    chk("R1 reset step", 64'(curStep), 64'd31);
    chk("R1 reset start", 64'(filtStart), 64'd0);
    for (int i = 0; i < 32; i++) hostWrite(4'd5, i, prog[i]);
    hostWrite(4'd3, 1, '1);                                 // R3 other channel
    for (int q = 0; q < 4; q++) hostRead(1, q);             // R2 readback
    randOn = 1'b1;
    for (int round = 0; round < 6; round++) begin
      @(negedge clk); holdBit = 1'b0;
      repeat (300) @(negedge clk);
      hostWrite(4'd5, 3, '0);                               // R3 ignored, hold low
      hostRead(2, 0);                                       // R3 rData unchanged
      repeat (200) @(negedge clk);
      holdBit = 1'b1;                                       // R4 freeze
      repeat (20) @(negedge clk);
      hostRead(round % 8, round % 4);
    end
    randOn = 1'b0;
    @(negedge clk); sampleIn = 1'b0;
    @(negedge clk);
    running = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule